// File: doc/BRIEF.md
# Conversion Scheduler with Trigger Mode

This block decides when a sensor front end begins a 10-bit analog-to-digital conversion. An 8-bit mode register chooses between two schemes. In the free-running scheme an internal period timer fires every 355 µs and launches a conversion. In the triggered scheme conversions begin only on a rising edge of an external convert-start pin, which is brought into the clock domain through a two-flop synchroniser. The same register carries a test bit that switches the serial input glitch filters in or out through a dedicated output.

Serial bus traffic and converting do not mix. If the bus becomes active while a conversion runs, the scheduler aborts it. It then relaunches it on the first idle bus cycle. A timer expiry that lands during bus traffic is held back and released in the same way. The analog converter is represented by a model that returns a done pulse a fixed number of cycles after each launch. The 10-bit result register, with one LSB equal to the reference over 1024, takes only the results of conversions that finished without an abort.

Top module: `conv_sched`

## Requirements
- R1: After reset the mode register reads 0x00, `filt_en` is 1, `busy` is 0, and `conv_start` and `conv_abort` are 0.
- R2: A write stores bit 7 (mode: 0 = free-running, 1 = triggered) and bit 6 (test bit). Bits 5..0 always read back as 0, whatever value is written.
- R3: `filt_en` is the inverse of mode register bit 6.
- R4: In free-running mode with no bus activity, consecutive `conv_start` pulses are exactly PERIOD_CYC = CLK_MHZ*PERIOD_US cycles apart.
- R5: In triggered mode a rising edge on `ext_cnv` while idle produces exactly one `conv_start` pulse within 8 cycles. The period timer launches nothing in this mode.
- R6: In triggered mode, rising edges on `ext_cnv` that arrive while `busy` is 1 are dropped and not queued.
- R7: `busy` rises in the same cycle as `conv_start`. For an uninterrupted conversion it stays high for CONV_CYC+1 cycles.
- R8: When `bus_active` is 1 while `busy` is 1, the next cycle shows `conv_abort` = 1 and `busy` = 0. No `conv_start` occurs while `bus_active` is 1. The conversion is relaunched so that `conv_start` is 1 in the cycle after `bus_active` is first seen low.
- R9: A period expiry during bus activity raises no abort and no start. Its start is issued in the cycle after the bus returns to idle.
- R10: `result` takes the `ain` value sampled at launch, and only when that conversion completes. An aborted conversion leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register contents |
| filt_en | output | 1 | Serial input glitch filter enable |
| ext_cnv | input | 1 | External convert-start pin (asynchronous) |
| bus_active | input | 1 | Serial bus transaction in progress |
| ain | input | 10 | Analog level presented to the converter model |
| conv_start | output | 1 | One-cycle conversion launch pulse |
| conv_abort | output | 1 | One-cycle abort pulse |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed conversion result |

## Verification
The hardest case to reach is a period expiry that falls inside a bus transaction while no conversion is running. The bench first locks onto a timer launch. It then counts a fixed offset past the end of that conversion and raises the bus across the point where the next expiry must fall. This proves that no abort or start leaks out and that the held launch appears in the cycle after release. Edges dropped while busy are covered the same way: a second trigger edge is placed while `busy` is confirmed high, and the bench watches for a launch until well after the conversion ends.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int MODE_BIT  = 7;
  localparam int TEST_BIT  = 6;
  localparam logic [7:0] KEEP_MASK = 8'hC0;
  localparam int RES_W     = 10;
endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[1] & ~sh_q[2];

  // R5
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cs_period_timer.sv
module cs_period_timer #(
  parameter int PERIOD_CYC = 35500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = $clog2(PERIOD_CYC + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD_CYC - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4
  wrap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);
endmodule

// File: rtl/cs_adc_model.sv
module cs_adc_model #(
  parameter int CONV_CYC = 40,
  parameter int RES_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [RES_W-1:0] ain,
  output logic             done,
  output logic [RES_W-1:0] data
);
  localparam int W = $clog2(CONV_CYC + 1);
  localparam logic [W-1:0] LAST = W'(CONV_CYC - 1);

  logic             run_q, run_d;
  logic [W-1:0]     cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [RES_W-1:0] data_q, data_d;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    data_d = data_q;
    if (abort) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      data_d = ain;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      data_q <= data_d;
    end
  end

  assign done = done_q;
  assign data = data_q;

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= LAST);
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PERIOD_US = 355,
  parameter int CONV_CYC  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             filt_en,
  input  logic             ext_cnv,
  input  logic             bus_active,
  input  logic [RES_W-1:0] ain,
  output logic             conv_start,
  output logic             conv_abort,
  output logic             busy,
  output logic [RES_W-1:0] result
);
  localparam int PERIOD_CYC = CLK_MHZ * PERIOD_US;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // mode register
  logic [7:0] cfg_q, cfg_d;
  logic       trig_mode;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) cfg_q <= 8'h00;
    else          cfg_q <= cfg_d;
  end

  assign trig_mode = cfg_q[MODE_BIT];
  assign cfg_rdata = cfg_q;
  assign filt_en   = ~cfg_q[TEST_BIT];

  // launch sources
  logic tick, ext_rise;

  cs_period_timer #(.PERIOD_CYC(PERIOD_CYC)) timer_i (
    .clk  (clk),
    .rst_n(rst_n_i),
    .run  (~trig_mode),
    .tick (tick)
  );

  cs_edge_sync sync_i (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .async_in(ext_cnv),
    .rise    (ext_rise)
  );

  // scheduling control
  logic             busy_q, busy_d;
  logic             pend_q, pend_d;
  logic             start_q, abort_q;
  logic             req_c, start_c, abort_c;
  logic             adc_done;
  logic [RES_W-1:0] adc_data;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    req_c   = ~busy_q & (trig_mode ? ext_rise : tick);
    start_c = (pend_q | req_c) & ~bus_active & ~busy_q;
    abort_c = busy_q & bus_active;

    pend_d = pend_q;
    if (start_c)     pend_d = 1'b0;
    else if (abort_c) pend_d = 1'b1;
    else if (req_c)   pend_d = 1'b1;

    busy_d = busy_q;
    if (start_c)                 busy_d = 1'b1;
    else if (abort_c || adc_done) busy_d = 1'b0;

    res_d = res_q;
    if (adc_done && !abort_c) res_d = adc_data;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      res_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      start_q <= start_c;
      abort_q <= abort_c;
      res_q   <= res_d;
    end
  end

  cs_adc_model #(.CONV_CYC(CONV_CYC), .RES_W(RES_W)) adc_i (
    .clk  (clk),
    .rst_n(rst_n_i),
    .start(start_c),
    .abort(abort_c),
    .ain  (ain),
    .done (adc_done),
    .data (adc_data)
  );

  assign conv_start = start_q;
  assign conv_abort = abort_q;
  assign busy       = busy_q;
  assign result     = res_q;

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    conv_start |-> busy);
  // R8
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy_q && bus_active) |=> (conv_abort && !busy));
  // R8
  no_start_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    conv_start |-> !$past(bus_active));
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !adc_done |=> $stable(result));
endmodule

// File: tb/conv_sched_tb_top.sv
module conv_sched_tb_top;
  localparam int PER  = 200;
  localparam int CONV = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       filt_en;
  logic       ext_cnv;
  logic       bus_active;
  logic [9:0] ain;
  logic       conv_start, conv_abort, busy;
  logic [9:0] result;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  conv_sched #(.CLK_MHZ(1), .PERIOD_US(PER), .CONV_CYC(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .filt_en(filt_en), .ext_cnv(ext_cnv),
    .bus_active(bus_active), .ain(ain), .conv_start(conv_start),
    .conv_abort(conv_abort), .busy(busy), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_start(output int n, input int lim);
    n = 0;
    while (!conv_start && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_starts(output int c, input int cycles);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (conv_start) c++;
    end
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
    chk(filt_en == 1'b1, "R1 filt_en", filt_en, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(!conv_start && !conv_abort, "R1 pulses", {conv_start, conv_abort}, 0);
  endtask

  task automatic t_cfg;
    cfg_write(8'h7F);
    chk(cfg_rdata == 8'h40, "R2 masked readback", cfg_rdata, 8'h40);
    chk(filt_en == 1'b0, "R3 filter off", filt_en, 0);
    cfg_write(8'h3F);
    chk(cfg_rdata == 8'h00, "R2 low bits zero", cfg_rdata, 0);
    chk(filt_en == 1'b1, "R3 filter on", filt_en, 1);
  endtask

  task automatic t_free;
    int n, b;
    ain = 10'h155;
    wait_start(n, 3 * PER);
    chk(conv_start == 1'b1, "R4 first start", conv_start, 1);
    chk(busy == 1'b1, "R7 busy with start", busy, 1);
    b = 0;
    while (busy && b < 4 * CONV) begin
      b++;
      @(negedge clk);
    end
    chk(b == CONV + 1, "R7 busy length", b, CONV + 1);
    chk(result == 10'h155, "R10 result after done", result, 10'h155);
    ain = 10'h2AA;
    wait_start(n, 3 * PER);
    chk(b + n == PER, "R4 start spacing", b + n, PER);
  endtask

  task automatic t_abort;
    int c;
    repeat (5) @(negedge clk);
    bus_active = 1'b1;
    @(negedge clk);
    chk(conv_abort == 1'b1, "R8 abort pulse", conv_abort, 1);
    chk(busy == 1'b0, "R8 busy dropped", busy, 0);
    chk(result == 10'h155, "R10 aborted keeps result", result, 10'h155);
    count_starts(c, 30);
    chk(c == 0, "R8 no start on bus", c, 0);
    bus_active = 1'b0;
    @(negedge clk);
    chk(conv_start == 1'b1, "R8 restart after idle", conv_start, 1);
    while (busy) @(negedge clk);
    chk(result == 10'h2AA, "R10 restarted result", result, 10'h2AA);
  endtask

  task automatic t_pend;
    int n, s, a;
    wait_start(n, 3 * PER);
    repeat (CONV + 60) @(negedge clk);
    bus_active = 1'b1;
    s = 0; a = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (conv_start) s++;
      if (conv_abort) a++;
    end
    chk(s == 0 && a == 0, "R9 held during bus", s + a, 0);
    bus_active = 1'b0;
    @(negedge clk);
    chk(conv_start == 1'b1, "R9 pending start issued", conv_start, 1);
  endtask

  task automatic t_trig;
    int c;
    while (busy) @(negedge clk);
    cfg_write(8'h80);
    chk(cfg_rdata == 8'h80, "R2 mode bit", cfg_rdata, 8'h80);
    count_starts(c, PER + 100);
    chk(c == 0, "R5 timer silent", c, 0);
    ext_cnv = 1'b1;
    count_starts(c, 8);
    chk(c == 1, "R5 one start per edge", c, 1);
    repeat (4) @(negedge clk);
    ext_cnv = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R6 busy at second edge", busy, 1);
    ext_cnv = 1'b1;
    count_starts(c, CONV + 40);
    chk(c == 0, "R6 edge while busy dropped", c, 0);
    ext_cnv = 1'b0;
    repeat (3) @(negedge clk);
    ext_cnv = 1'b1;
    count_starts(c, 8);
    chk(c == 1, "R5 edge when idle", c, 1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; ext_cnv = 1'b0;
    bus_active = 1'b0; ain = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_cfg;
    t_free;
    t_abort;
    t_pend;
    t_trig;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule